// File: doc/BRIEF.md
# Line-Frequency All-Digital Phase-Locked Loop

This block follows a 50/60 Hz mains waveform that arrives as signed samples, one per strobe, and produces a sine and a cosine locked to it. The whole loop is arithmetic in fabric, clocked by the system clock and advanced only on sample strobes. No clock-management primitive is involved, because the line frequency is far below what such primitives accept.

A numerically controlled oscillator keeps a phase accumulator and derives both quadrature outputs from a sine law that is computed over a quarter wave. The phase detector multiplies each incoming sample by the oscillator cosine. A moving sum over one nominal line period then removes the double-frequency ripple of that product. A proportional-integral filter turns the smoothed error into a correction of the tuning word. A lock indicator watches the smoothed error once per line period.

Control logic counts samples into line periods and drives a small set of strobes into the datapath.

Top module: `lineAdpll`

## Requirements
- R1: After reset, phaseWord is 0, freqWord equals CENTER_WORD (42949673, which is 60 Hz at 100 samples per period), locked is 0, sinOut is 510 and cosOut is 32766.
- R2: On each clock with sampleValid high, phaseWord advances by the freqWord value held before that edge, modulo 2^32. Without a strobe, phaseWord, freqWord and all loop state hold.
- R3: With a = phaseWord[31:24], k = a[5:0] when a[6] is 0 and 63 - a[5:0] otherwise, the magnitude is 2*(2k+1)*(255-2k). sinOut is this magnitude, negated when a[7] is 1. cosOut is the same law evaluated at a+64 (mod 256).
- R4: On each strobe, the product sampleIn*cosOut enters a moving sum that always covers the latest 100 products. Products older than that leave the sum.
- R5: On each strobe, the new tuning word is CENTER_WORD + (S >>> 14) + I. Here S is the updated moving sum and I is the updated integrator, I = old I + (S >>> 25).
- R6: The integrator saturates at plus and minus CENTER_WORD/10 (4294967) instead of wrapping.
- R7: freqWord never leaves the range CENTER_WORD - 4294967 to CENTER_WORD + 4294967. Sustained one-sided error pins it to the matching limit.
- R8: The 100th strobe of each period is its period end. At a period end, the error is in band when the updated moving sum S satisfies |S| < 2^30. locked rises after the period end that completes 16 consecutive in-band periods.
- R9: locked falls after the first period end whose error is out of band, and the in-band run count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | One-cycle strobe marking a new input sample |
| sampleIn | input | 16 | Signed line-voltage sample |
| sinOut | output | 16 | Signed oscillator sine |
| cosOut | output | 16 | Signed oscillator cosine |
| phaseWord | output | 32 | Oscillator phase accumulator |
| freqWord | output | 32 | Current tuning word |
| locked | output | 1 | Lock indicator |

## Verification
A clean 60 Hz sine that starts in phase with the oscillator shows whether the loop settles and raises the lock flag on the expected period. A step to 63 Hz shows whether the flag drops and whether the integrator pulls the frequency over. Feeding back the block's own cosine, and then its negation, makes the phase detector output one-sided. That drives the integrator and the tuning word into their positive and then negative limits. A following stretch of zero input then shows whether the integrator held its saturated value or wrapped. Idle gaps between strobes tell a loop that holds its state apart from one that drifts on the clock.

// File: rtl/adpllPkg.sv
package adpllPkg;
  typedef struct packed {
    logic advance;
    logic periodEnd;
  } loopStrobe_t;
endpackage

// File: rtl/adpllSine.sv
module adpllSine #(
  parameter int LUT_AW = 8,
  parameter int AMP_W  = 16
) (
  input  logic [LUT_AW-1:0]       addr,
  output logic signed [AMP_W-1:0] value
);
  localparam int Q_W      = LUT_AW - 2;
  localparam int PW       = 2 * Q_W + 2;
  localparam int SPAN     = 1 << (Q_W + 2);
  localparam int SCALE_SH = AMP_W - 1 - PW;

  logic [Q_W-1:0]          idx;
  logic [PW-1:0]           oddW, complW, parab;
  logic signed [AMP_W-1:0] mag;

  always_comb begin
    idx    = addr[LUT_AW-2] ? ~addr[Q_W-1:0] : addr[Q_W-1:0];
    oddW   = PW'({idx, 1'b1});
    complW = PW'(SPAN) - oddW;
    parab  = oddW * complW;
    mag    = AMP_W'(parab) << SCALE_SH;
    value  = addr[LUT_AW-1] ? -mag : mag;
  end
endmodule

// File: rtl/adpllControl.sv
module adpllControl
  import adpllPkg::*;
#(
  parameter int PERIOD_SAMPLES = 100,
  parameter int LOCK_PERIODS   = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleValid,
  input  logic        errInBand,
  output loopStrobe_t strobe,
  output logic        locked
);
  localparam int CNT_W = $clog2(PERIOD_SAMPLES);
  localparam int LCK_W = $clog2(LOCK_PERIODS + 1);

  logic [CNT_W-1:0] sampleCnt;
  logic [LCK_W-1:0] goodRun;

  assign strobe.advance   = sampleValid;
  assign strobe.periodEnd = sampleValid && (sampleCnt == CNT_W'(PERIOD_SAMPLES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleCnt <= '0;
      goodRun   <= '0;
      locked    <= 1'b0;
    end else begin
      if (strobe.advance)
        sampleCnt <= strobe.periodEnd ? '0 : sampleCnt + 1'b1;
      if (strobe.periodEnd) begin
        if (errInBand) begin
          if (goodRun != LCK_W'(LOCK_PERIODS)) goodRun <= goodRun + 1'b1;
          if (goodRun >= LCK_W'(LOCK_PERIODS - 1)) locked <= 1'b1;
        end else begin
          goodRun <= '0;
          locked  <= 1'b0;
        end
      end
    end
  end

  // R9: a bad period end always clears the flag
  p_unlock_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.periodEnd && !errInBand |=> !locked);
  // R8: the flag only rises at a good period end finishing the run
  p_lock_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(strobe.periodEnd && errInBand)
                      && $past(goodRun) >= LCK_W'(LOCK_PERIODS - 1));
  // R8: the flag changes only at period ends
  p_lock_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.periodEnd |=> $stable(locked));
endmodule

// File: rtl/adpllDatapath.sv
module adpllDatapath
  import adpllPkg::*;
#(
  parameter int     SAMPLE_W       = 16,
  parameter int     NCO_W          = 32,
  parameter int     LUT_AW         = 8,
  parameter int     AMP_W          = 16,
  parameter int     PERIOD_SAMPLES = 100,
  parameter longint CENTER_WORD    = 42949673,
  parameter int     KP_SHIFT       = 14,
  parameter int     KI_SHIFT       = 25,
  parameter longint LOCK_THRESH    = 64'sd1073741824
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  loopStrobe_t                strobe,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  output logic signed [AMP_W-1:0]    sinOut,
  output logic signed [AMP_W-1:0]    cosOut,
  output logic [NCO_W-1:0]           phaseWord,
  output logic [NCO_W-1:0]           freqWord,
  output logic                       errInBand
);
  localparam int PROD_W = SAMPLE_W + AMP_W;
  localparam int SUM_W  = PROD_W + $clog2(PERIOD_SAMPLES) + 1;
  localparam int CTRL_W = ((SUM_W > NCO_W) ? SUM_W : NCO_W) + 2;
  localparam int PTR_W  = $clog2(PERIOD_SAMPLES);
  localparam int QTR    = 1 << (LUT_AW - 2);
  localparam logic signed [CTRL_W-1:0] CENTER_S = CTRL_W'(CENTER_WORD);
  localparam logic signed [CTRL_W-1:0] DEV_S    = CTRL_W'(CENTER_WORD / 10);
  localparam logic signed [CTRL_W-1:0] HI_S     = CENTER_S + DEV_S;
  localparam logic signed [CTRL_W-1:0] LO_S     = CENTER_S - DEV_S;
  localparam logic signed [SUM_W-1:0]  THR_S    = SUM_W'(LOCK_THRESH);
  localparam logic [NCO_W-1:0]         FREQ_HI  = HI_S[NCO_W-1:0];
  localparam logic [NCO_W-1:0]         FREQ_LO  = LO_S[NCO_W-1:0];

  logic [NCO_W-1:0]           phaseAcc, tuneWord;
  logic signed [SUM_W-1:0]    errSum, errSumNext;
  logic signed [PROD_W-1:0]   history [PERIOD_SAMPLES];
  logic [PTR_W-1:0]           wrPtr;
  logic signed [PROD_W-1:0]   product;
  logic signed [CTRL_W-1:0]   integ, integRaw, integNext, propTerm, integInc;
  logic signed [CTRL_W-1:0]   tuneRaw, tuneClamp;
  logic [LUT_AW-1:0]          lutAddr [2];
  logic signed [AMP_W-1:0]    waveVal [2];

  for (genvar g = 0; g < 2; g++) begin : gWave
    assign lutAddr[g] = phaseAcc[NCO_W-1 -: LUT_AW] + LUT_AW'(g * QTR);
    adpllSine #(.LUT_AW(LUT_AW), .AMP_W(AMP_W)) u_sine (
      .addr (lutAddr[g]),
      .value(waveVal[g])
    );
  end

  always_comb begin
    product    = PROD_W'(sampleIn) * PROD_W'(waveVal[1]);
    errSumNext = errSum + SUM_W'(product) - SUM_W'(history[wrPtr]);
    propTerm   = CTRL_W'(errSumNext >>> KP_SHIFT);
    integInc   = CTRL_W'(errSumNext >>> KI_SHIFT);
    integRaw   = integ + integInc;
    if (integRaw > DEV_S)       integNext = DEV_S;
    else if (integRaw < -DEV_S) integNext = -DEV_S;
    else                        integNext = integRaw;
    tuneRaw = CENTER_S + propTerm + integNext;
    if (tuneRaw > HI_S)      tuneClamp = HI_S;
    else if (tuneRaw < LO_S) tuneClamp = LO_S;
    else                     tuneClamp = tuneRaw;
    errInBand = (errSumNext < THR_S) && (errSumNext > -THR_S);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseAcc <= '0;
      tuneWord <= CENTER_S[NCO_W-1:0];
      integ    <= '0;
      errSum   <= '0;
      wrPtr    <= '0;
      for (int i = 0; i < PERIOD_SAMPLES; i++) history[i] <= '0;
    end else if (strobe.advance) begin
      phaseAcc        <= phaseAcc + tuneWord;
      tuneWord        <= tuneClamp[NCO_W-1:0];
      integ           <= integNext;
      errSum          <= errSumNext;
      history[wrPtr]  <= product;
      wrPtr           <= (wrPtr == PTR_W'(PERIOD_SAMPLES - 1)) ? '0 : wrPtr + 1'b1;
    end
  end

  assign sinOut    = waveVal[0];
  assign cosOut    = waveVal[1];
  assign phaseWord = phaseAcc;
  assign freqWord  = tuneWord;

  // R2: no strobe, no motion
  p_phase_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.advance |=> $stable(phaseAcc) && $stable(tuneWord));
  // R4: the moving sum only changes on a strobe
  p_sum_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.advance |=> $stable(errSum));
  // R6: integrator stays within its limits
  p_integ_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    integ <= DEV_S && integ >= -DEV_S);
  // R7: tuning word stays within its clamp
  p_freq_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    tuneWord <= FREQ_HI && tuneWord >= FREQ_LO);
endmodule

// File: rtl/lineAdpll.sv
module lineAdpll
  import adpllPkg::*;
#(
  parameter int     SAMPLE_W       = 16,
  parameter int     NCO_W          = 32,
  parameter int     LUT_AW         = 8,
  parameter int     AMP_W          = 16,
  parameter int     PERIOD_SAMPLES = 100,
  parameter longint CENTER_WORD    = 42949673,
  parameter int     KP_SHIFT       = 14,
  parameter int     KI_SHIFT       = 25,
  parameter longint LOCK_THRESH    = 64'sd1073741824,
  parameter int     LOCK_PERIODS   = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sampleValid,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  output logic signed [AMP_W-1:0]    sinOut,
  output logic signed [AMP_W-1:0]    cosOut,
  output logic [NCO_W-1:0]           phaseWord,
  output logic [NCO_W-1:0]           freqWord,
  output logic                       locked
);
  loopStrobe_t strobe;
  logic        errInBand;

  adpllControl #(
    .PERIOD_SAMPLES(PERIOD_SAMPLES),
    .LOCK_PERIODS  (LOCK_PERIODS)
  ) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .errInBand  (errInBand),
    .strobe     (strobe),
    .locked     (locked)
  );

  adpllDatapath #(
    .SAMPLE_W      (SAMPLE_W),
    .NCO_W         (NCO_W),
    .LUT_AW        (LUT_AW),
    .AMP_W         (AMP_W),
    .PERIOD_SAMPLES(PERIOD_SAMPLES),
    .CENTER_WORD   (CENTER_WORD),
    .KP_SHIFT      (KP_SHIFT),
    .KI_SHIFT      (KI_SHIFT),
    .LOCK_THRESH   (LOCK_THRESH)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .sampleIn (sampleIn),
    .sinOut   (sinOut),
    .cosOut   (cosOut),
    .phaseWord(phaseWord),
    .freqWord (freqWord),
    .errInBand(errInBand)
  );
endmodule

// File: tb/lineAdpll_bench.sv
module lineAdpll_bench;
  localparam longint CENTER = 42949673;
  localparam longint DEV    = CENTER / 10;
  localparam longint HI     = CENTER + DEV;
  localparam longint LO     = CENTER - DEV;
  localparam longint THR    = 64'sd1073741824;
  localparam int     PERIOD = 100;
  localparam real    FS     = 6000.0;
  localparam real    TWO_PI = 6.283185307179586;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic signed [15:0] sampleIn = '0;
  logic signed [15:0] sinOut, cosOut;
  logic [31:0] phaseWord, freqWord;
  logic locked;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  lineAdpll u_lineAdpll (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .sinOut(sinOut), .cosOut(cosOut), .phaseWord(phaseWord),
    .freqWord(freqWord), .locked(locked)
  );

  // reference model state
  longint mHist[$];
  longint mSum, mInteg, mTune, mPhase;
  int     mCnt, mRun;
  bit     mLocked;

  function automatic longint sineLaw(longint a);
    longint k, mag;
    a = a & 255;
    k = a & 63;
    if ((a & 64) != 0) k = 63 - k;
    mag = 2 * (2 * k + 1) * (255 - 2 * k);
    return ((a & 128) != 0) ? -mag : mag;
  endfunction

  task automatic check(string tag, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mHist.delete();
      for (int i = 0; i < PERIOD; i++) mHist.push_back(0);
      mSum = 0; mInteg = 0; mTune = CENTER; mPhase = 0;
      mCnt = 0; mRun = 0; mLocked = 0;
    end else if (sampleValid) begin
      longint x, c, prod, old, t;
      bit inBand;
      x = longint'(sampleIn);
      c = sineLaw((mPhase >> 24) + 64);
      prod = x * c;
      old = mHist.pop_front();
      mHist.push_back(prod);
      mSum = mSum + prod - old;
      mInteg = mInteg + (mSum >>> 25);
      if (mInteg > DEV) mInteg = DEV;
      if (mInteg < -DEV) mInteg = -DEV;
      t = CENTER + (mSum >>> 14) + mInteg;
      if (t > HI) t = HI;
      if (t < LO) t = LO;
      mPhase = (mPhase + mTune) & 64'hFFFF_FFFF;
      mTune = t;
      inBand = (mSum < THR) && (mSum > -THR);
      if (mCnt == PERIOD - 1) begin
        mCnt = 0;
        if (inBand) begin
          if (mRun >= 15) mLocked = 1;
          if (mRun < 16) mRun++;
        end else begin
          mRun = 0;
          mLocked = 0;
        end
      end else mCnt++;
    end
  end

  // clock-by-clock comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R2 phase", longint'(phaseWord), mPhase);
      check("R5,R6,R7 freq", longint'(freqWord), mTune);
      check("R3 sine", longint'(sinOut), sineLaw(mPhase >> 24));
      check("R3,R4 cosine", longint'(cosOut), sineLaw((mPhase >> 24) + 64));
      check("R8,R9 lock", longint'(locked), longint'(mLocked));
    end
  end

  real thIn = 0.0;

  task automatic pushSample(logic signed [15:0] v);
    @(negedge clk);
    sampleValid = 1'b1;
    sampleIn = v;
    @(negedge clk);
    sampleValid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic feedTone(real hz, int periods, output bit sawLow);
    sawLow = 1'b0;
    for (int n = 0; n < periods * PERIOD; n++) begin
      pushSample(16'($rtoi(16000.0 * $sin(thIn))));
      thIn = thIn + TWO_PI * hz / FS;
      if (!locked) sawLow = 1'b1;
    end
  endtask

  task automatic feedSelf(bit negate, int periods);
    for (int n = 0; n < periods * PERIOD; n++) begin
      @(negedge clk);
      sampleValid = 1'b1;
      sampleIn = negate ? -cosOut : cosOut;
      @(negedge clk);
      sampleValid = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic feedZero(int periods);
    for (int n = 0; n < periods * PERIOD; n++) pushSample('0);
  endtask

  task automatic finish();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish();
  end

  initial begin
    bit sawLow;
    logic [31:0] heldPhase, heldFreq;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 phase", longint'(phaseWord), 0);
    check("R1 freq", longint'(freqWord), CENTER);
    check("R1 lock", longint'(locked), 0);
    check("R1 sine", longint'(sinOut), 510);
    check("R1 cosine", longint'(cosOut), 32766);

    // R8: clean in-phase 60 Hz input locks within 25 periods
    feedTone(60.0, 25, sawLow);
    check("R8 locked after clean tone", longint'(locked), 1);

    // R2: idle clocks leave the loop untouched
    heldPhase = phaseWord;
    heldFreq = freqWord;
    repeat (12) @(negedge clk);
    check("R2 phase held", longint'(phaseWord), longint'(heldPhase));
    check("R2 freq held", longint'(freqWord), longint'(heldFreq));

    // R9: frequency step breaks lock
    feedTone(63.0, 30, sawLow);
    check("R9 lock lost on step", longint'(sawLow), 1);

    // R7/R6: one-sided error drives the upper limit
    feedSelf(1'b0, 40);
    check("R7 upper clamp", longint'(freqWord), HI);
    feedZero(3);
    check("R6 integrator held at upper limit", longint'(freqWord), HI);

    // R7/R6: opposite error drives the lower limit
    feedSelf(1'b1, 80);
    check("R7 lower clamp", longint'(freqWord), LO);
    feedZero(3);
    check("R6 integrator held at lower limit", longint'(freqWord), LO);

    finish();
  end
endmodule